// File: doc/BRIEF.md
# Secure System Control Register Bank

This block is a bank of 32-bit control and status words behind an APB slave port with a 4 KB window. Software uses it to look at and change the secure debug state, to read why the system last reset, to keep one word across warm resets, to set the boot vector address of each core, and to hold cores in boot until it releases them. It also holds clock divider and clock force words, power domain sense words and a fixed set of identification words. The divider, force and sense words are plain storage. Nothing in the block divides a clock or sequences a power domain.

The build parameter `ONE_CORE` picks one of two variants. The two-core variant (`ONE_CORE = 0`) has two vector words and two hold bits. The single-core variant (`ONE_CORE = 1`) moves the hold word and the NMI enable word to other offsets and retires some offsets. It also adds two protections: a self-lock bit on vector word 0, and a power control word that only accepts writes while its unlock bit is set. The block drives three kinds of output. A software reset request pulse and one release pulse per core are both registered. The boot vector values are level outputs.

The bus never applies back-pressure: `pready` is tied high and `pslverr` tied low. Every transfer therefore completes in its first access cycle. Reads return the whole word, whatever the byte strobes are.

Top module: `sec_sysctrl`

## Requirements
- R1: After reset these words read as follows: reset cause (0x100) 0x1, system sense (0x200) 0x7F, both vector words (0x110, 0x114) 0x10000000, power control (0x1FC, single-core variant) 0x3, and every other read/write word 0. No output pulse is active after reset.
- R2: A write to a read/write word changes only the byte lanes whose `pstrb` bit is set. A read returns the full 32-bit word. On every transfer `pready` is 1 and `pslverr` is 0.
- R3: The debug status word at 0x000 can only be read. A write to 0x004 ORs the strobed data into the status word. A write to 0x008 clears each status bit where the strobed data is 1. Reads of 0x004, 0x008 and 0x108 return 0.
- R4: A write to 0x108 with bit 9 set (byte lane 1 strobed) raises `sw_reset_req` for exactly one clock, in the cycle after the access phase. A write to 0x108 with bit 9 clear raises nothing.
- R5: When a write changes a core's hold bit from 1 to 0, the block raises that core's bit of `core_release` for exactly one clock, in the cycle after the access phase. Bit n of the hold word belongs to core n. The two-core variant has cores 0 and 1. The single-core variant has only core 0, and its bit 1 never fires.
- R6: In the single-core variant, bit 0 of vector word 0 is a lock. Once that bit reads 1, every later write to the word is dropped. In this variant `boot_vec0` carries bits 31:7 of the word, with bits 6:0 forced to 0. In the two-core variant `boot_vec0` is the whole word and there is no lock.
- R7: In the single-core variant, a write to power control (0x1FC) takes effect only if bit 0 of that word reads 1 at the time of the write.
- R8: Two-core offset map: 0x114 is vector word 1, 0x118 is the hold word, 0x11C is NMI enable, 0x120 is wake control, 0x124 is early wake control, and 0x1FC and 0x204 are invalid. Single-core offset map: 0x120 is the hold word, 0x124 is NMI enable, 0x204 is the core sense word, and 0x114, 0x118, 0x11C, 0x20C and 0x210 are invalid.
- R9: The twelve words from 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these words have no effect.
- R10: Unmapped and variant-invalid offsets read as 0. Writes to them, to the ID words and to 0x000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr_w | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte-lane strobes |
| prdata | output | 32 | Read data; 0 when no read is selected |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| sw_reset_req | output | 1 | One-clock software reset request |
| core_release | output | 2 | One-clock release pulse per core |
| boot_vec0 | output | 32 | Boot vector for core 0 |
| boot_vec1 | output | 32 | Boot vector for core 1 |

## Verification
Nearly all internal state can be read back over the bus. A wrong stored value, a lost byte lane or a merge that is set or cleared the wrong way therefore shows on `prdata` at the next read of that offset. A faulty vector lock or power unlock gate shows the same way. A wrong vector word also shows on `boot_vec0` in the clock right after the write. A wrong hold bit, or a wrong transition test on it, shows as a missing or extra `core_release` pulse one clock after the access phase. A decode error between the variants shows as data that lands at, or reads from, a neighbouring offset. The bench drives both variants side by side so that such aliasing is caught.

// File: rtl/sec_sysctrl_pkg.sv
`timescale 1ns/1ps
package sec_sysctrl_pkg;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int WAW       = AW - 2;
  localparam int SW        = DW / 8;
  localparam int MAX_CPU   = 2;
  localparam int SWRST_BIT = 9;
  localparam int VEC_LSB   = 7;

  typedef enum logic [4:0] {
    SL_DBG, SL_SECCTL, SL_FCLK, SL_SYSCLK, SL_CLKF, SL_RSYN, SL_RMASK,
    SL_RETAIN, SL_VT0, SL_VT1, SL_WAIT, SL_NMI, SL_WAKE, SL_EWAKE, SL_PWR,
    SL_SN_SYS, SL_SN_CPU, SL_SN_A, SL_SN_B, SL_SN_C, SL_SN_D
  } slot_e;
  localparam int NSLOT = 21;

  typedef enum logic [2:0] {K_BAD, K_RW, K_RO, K_ID, K_SET, K_CLR, K_SWRST} acc_e;

  typedef struct packed {
    acc_e       kind;
    slot_e      slot;
    logic [7:0] id;
  } dec_t;

  function automatic logic [DW-1:0] lane_mask(input logic [SW-1:0] s);
    logic [DW-1:0] m;
    for (int b = 0; b < SW; b++) m[b*8 +: 8] = {8{s[b]}};
    return m;
  endfunction
endpackage

// File: rtl/sysctrl_decode.sv
`timescale 1ns/1ps
module sysctrl_decode
  import sec_sysctrl_pkg::*;
#(
  parameter bit ONE_CORE = 1'b0
) (
  input  logic [WAW-1:0] wa,
  output dec_t           dec
);
  localparam logic [WAW-1:0] ID_BASE = WAW'(12'hFD0 >> 2);

  logic [AW-1:0]  ba;
  logic [WAW-1:0] id_off;
  assign ba     = {wa, 2'b00};
  assign id_off = wa - ID_BASE;

  function automatic logic [7:0] id_byte(input logic [WAW-1:0] k);
    case (k)
      0: return 8'h04;
      4: return 8'h54;
      5: return 8'hB8;
      6: return 8'h1B;
      8: return 8'h0D;
      9: return 8'hF0;
      10: return 8'h05;
      11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    dec = '{kind: K_BAD, slot: SL_DBG, id: 8'h00};
    case (ba)
      12'h000: dec.kind = K_RO;
      12'h004: dec.kind = K_SET;
      12'h008: dec.kind = K_CLR;
      12'h00C: begin dec.kind = K_RW; dec.slot = SL_SECCTL; end
      12'h010: begin dec.kind = K_RW; dec.slot = SL_FCLK;   end
      12'h014: begin dec.kind = K_RW; dec.slot = SL_SYSCLK; end
      12'h018: begin dec.kind = K_RW; dec.slot = SL_CLKF;   end
      12'h100: begin dec.kind = K_RW; dec.slot = SL_RSYN;   end
      12'h104: begin dec.kind = K_RW; dec.slot = SL_RMASK;  end
      12'h108: dec.kind = K_SWRST;
      12'h10C: begin dec.kind = K_RW; dec.slot = SL_RETAIN; end
      12'h110: begin dec.kind = K_RW; dec.slot = SL_VT0;    end
      12'h114: if (!ONE_CORE) begin dec.kind = K_RW; dec.slot = SL_VT1;  end
      12'h118: if (!ONE_CORE) begin dec.kind = K_RW; dec.slot = SL_WAIT; end
      12'h11C: if (!ONE_CORE) begin dec.kind = K_RW; dec.slot = SL_NMI;  end
      12'h120: begin dec.kind = K_RW; dec.slot = ONE_CORE ? SL_WAIT : SL_WAKE;  end
      12'h124: begin dec.kind = K_RW; dec.slot = ONE_CORE ? SL_NMI  : SL_EWAKE; end
      12'h1FC: if (ONE_CORE)  begin dec.kind = K_RW; dec.slot = SL_PWR;    end
      12'h200: begin dec.kind = K_RW; dec.slot = SL_SN_SYS; end
      12'h204: if (ONE_CORE)  begin dec.kind = K_RW; dec.slot = SL_SN_CPU; end
      12'h20C: if (!ONE_CORE) begin dec.kind = K_RW; dec.slot = SL_SN_A;   end
      12'h210: if (!ONE_CORE) begin dec.kind = K_RW; dec.slot = SL_SN_B;   end
      12'h214: begin dec.kind = K_RW; dec.slot = SL_SN_C; end
      12'h218: begin dec.kind = K_RW; dec.slot = SL_SN_D; end
      default: begin
        if (wa >= ID_BASE) begin
          dec.kind = K_ID;
          dec.id   = id_byte(id_off);
        end
      end
    endcase
  end
endmodule

// File: rtl/sysctrl_regfile.sv
`timescale 1ns/1ps
module sysctrl_regfile
  import sec_sysctrl_pkg::*;
#(
  parameter bit          ONE_CORE = 1'b0,
  parameter logic [31:0] VEC0_RST = 32'h1000_0000,
  parameter logic [31:0] VEC1_RST = 32'h1000_0000,
  parameter logic [31:0] WAIT_RST = 32'h0
) (
  input  logic          clk,
  input  logic          rstn,
  input  logic          wr_en,
  input  acc_e          kind,
  input  slot_e         slot,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  output logic [DW-1:0] slot_word [NSLOT],
  output logic [MAX_CPU-1:0] rel_fire
);
  localparam int NCPU = ONE_CORE ? 1 : 2;

  function automatic logic [DW-1:0] rst_val(input int s);
    if (s == int'(SL_RSYN))   return 32'h1;
    if (s == int'(SL_SN_SYS)) return 32'h7F;
    if (s == int'(SL_VT0))    return VEC0_RST;
    if (s == int'(SL_VT1))    return VEC1_RST;
    if (s == int'(SL_WAIT))   return WAIT_RST;
    if (s == int'(SL_PWR))    return 32'h3;
    return '0;
  endfunction

  logic [DW-1:0] wd_m;
  assign wd_m = wdata & wmask;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [DW-1:0] q, nxt;
    logic          take;
    always_comb begin
      take = 1'b0;
      nxt  = (q & ~wmask) | wd_m;
      if (wr_en && int'(slot) == i) begin
        if (i == int'(SL_DBG)) begin
          take = (kind == K_SET) || (kind == K_CLR);
          nxt  = (kind == K_SET) ? (q | wd_m) : (q & ~wd_m);
        end else if (i == int'(SL_VT0) && ONE_CORE) begin
          take = (kind == K_RW) && !q[0];
        end else if (i == int'(SL_PWR)) begin
          take = (kind == K_RW) && q[0];
        end else begin
          take = (kind == K_RW);
        end
      end
    end
    always_ff @(posedge clk or negedge rstn) begin
      if (!rstn)     q <= rst_val(i);
      else if (take) q <= nxt;
    end
    assign slot_word[i] = q;
  end

  logic          wait_take;
  logic [DW-1:0] wait_new;
  assign wait_take = wr_en && (kind == K_RW) && (slot == SL_WAIT);
  assign wait_new  = (slot_word[SL_WAIT] & ~wmask) | wd_m;

  for (genvar c = 0; c < MAX_CPU; c++) begin : g_rel
    if (c < NCPU) begin : g_on
      assign rel_fire[c] = wait_take && slot_word[SL_WAIT][c] && !wait_new[c];
    end else begin : g_off
      assign rel_fire[c] = 1'b0;
    end
  end

  // R3: a clear alias write leaves none of the written ones set
  p_dbg_clear_r3: assert property (@(posedge clk) disable iff (!rstn)
    (wr_en && kind == K_CLR) |=> ((slot_word[SL_DBG] & $past(wd_m)) == '0));

  // R7: a locked power word does not move
  p_pwr_lock_r7: assert property (@(posedge clk) disable iff (!rstn)
    !slot_word[SL_PWR][0] |=> $stable(slot_word[SL_PWR]));

  if (ONE_CORE) begin : g_lock_chk
    // R6: once the lock bit is set the vector word is frozen
    p_vec_lock_r6: assert property (@(posedge clk) disable iff (!rstn)
      slot_word[SL_VT0][0] |=> $stable(slot_word[SL_VT0]));
  end
endmodule

// File: rtl/sysctrl_pulse.sv
`timescale 1ns/1ps
module sysctrl_pulse #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstn,
  input  logic [W-1:0] fire,
  output logic [W-1:0] pulse
);
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) pulse <= '0;
    else       pulse <= fire;
  end
endmodule

// File: rtl/sec_sysctrl.sv
`timescale 1ns/1ps
module sec_sysctrl
  import sec_sysctrl_pkg::*;
#(
  parameter bit          ONE_CORE = 1'b0,
  parameter logic [31:0] VEC0_RST = 32'h1000_0000,
  parameter logic [31:0] VEC1_RST = 32'h1000_0000,
  parameter logic [31:0] WAIT_RST = 32'h0
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [WAW-1:0]     paddr_w,
  input  logic [DW-1:0]      pwdata,
  input  logic [SW-1:0]      pstrb,
  output logic [DW-1:0]      prdata,
  output logic               pready,
  output logic               pslverr,
  output logic               sw_reset_req,
  output logic [MAX_CPU-1:0] core_release,
  output logic [DW-1:0]      boot_vec0,
  output logic [DW-1:0]      boot_vec1
);
  dec_t               dec;
  logic               wr_en;
  logic [DW-1:0]      wmask;
  logic [DW-1:0]      slot_word [NSLOT];
  logic [MAX_CPU-1:0] rel_fire;
  logic               swrst_fire;
  logic [DW-1:0]      rd_word;

  assign wr_en      = psel && penable && pwrite;
  assign wmask      = lane_mask(pstrb);
  assign swrst_fire = wr_en && (dec.kind == K_SWRST) && pwdata[SWRST_BIT] && wmask[SWRST_BIT];

  sysctrl_decode #(.ONE_CORE(ONE_CORE)) u_decode (
    .wa  (paddr_w),
    .dec (dec)
  );

  sysctrl_regfile #(
    .ONE_CORE (ONE_CORE),
    .VEC0_RST (VEC0_RST),
    .VEC1_RST (VEC1_RST),
    .WAIT_RST (WAIT_RST)
  ) u_regs (
    .clk       (pclk),
    .rstn      (presetn),
    .wr_en     (wr_en),
    .kind      (dec.kind),
    .slot      (dec.slot),
    .wdata     (pwdata),
    .wmask     (wmask),
    .slot_word (slot_word),
    .rel_fire  (rel_fire)
  );

  sysctrl_pulse #(.W(MAX_CPU + 1)) u_pulse (
    .clk   (pclk),
    .rstn  (presetn),
    .fire  ({rel_fire, swrst_fire}),
    .pulse ({core_release, sw_reset_req})
  );

  always_comb begin
    rd_word = '0;
    case (dec.kind)
      K_RO, K_RW: rd_word = slot_word[dec.slot];
      K_ID:       rd_word = {{(DW-8){1'b0}}, dec.id};
      default:    rd_word = '0;
    endcase
  end

  assign prdata  = (psel && !pwrite) ? rd_word : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  if (ONE_CORE) begin : g_vec_trim
    assign boot_vec0 = {slot_word[SL_VT0][DW-1:VEC_LSB], {VEC_LSB{1'b0}}};
  end else begin : g_vec_full
    assign boot_vec0 = slot_word[SL_VT0];
  end
  assign boot_vec1 = slot_word[SL_VT1];

  // R4: a reset request follows a software reset write with bit 9 set
  p_swrst_cause_r4: assert property (@(posedge pclk) disable iff (!presetn)
    sw_reset_req |-> $past(psel && penable && pwrite && (paddr_w == WAW'(12'h108 >> 2))
                           && pwdata[SWRST_BIT] && pstrb[SWRST_BIT/8]));

  // R4: the request never lasts two clocks
  p_swrst_single_r4: assert property (@(posedge pclk) disable iff (!presetn)
    sw_reset_req |=> !sw_reset_req);

  for (genvar c = 0; c < MAX_CPU; c++) begin : g_rel_chk
    // R5: a release pulse leaves its hold bit cleared
    p_release_clear_r5: assert property (@(posedge pclk) disable iff (!presetn)
      core_release[c] |-> !slot_word[SL_WAIT][c]);
  end
endmodule

// File: tb/sec_sysctrl_bench.sv
`timescale 1ns/1ps
module sec_sysctrl_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        sel_a = 1'b0, sel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr_w = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;

  logic [31:0] prdata_a, prdata_b, vec0_a, vec0_b, vec1_a, vec1_b;
  logic        pready_a, pready_b, pslverr_a, pslverr_b, swr_a, swr_b;
  logic [1:0]  rel_a, rel_b;

  always #2.5 pclk = ~pclk;

  sec_sysctrl u_sec_sysctrl (
    .pclk(pclk), .presetn(presetn), .psel(sel_a), .penable(penable), .pwrite(pwrite),
    .paddr_w(paddr_w), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata_a),
    .pready(pready_a), .pslverr(pslverr_a), .sw_reset_req(swr_a),
    .core_release(rel_a), .boot_vec0(vec0_a), .boot_vec1(vec1_a));

  sec_sysctrl #(.ONE_CORE(1'b1)) u_sec_sysctrl_one (
    .pclk(pclk), .presetn(presetn), .psel(sel_b), .penable(penable), .pwrite(pwrite),
    .paddr_w(paddr_w), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata_b),
    .pready(pready_b), .pslverr(pslverr_b), .sw_reset_req(swr_b),
    .core_release(rel_b), .boot_vec0(vec0_b), .boot_vec1(vec1_b));

  typedef struct { bit side; logic [31:0] exp; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit side, input logic [11:0] addr, input logic [31:0] d,
                    input logic [3:0] s);
    @(negedge pclk);
    sel_a = !side; sel_b = side; pwrite = 1'b1; penable = 1'b0;
    paddr_w = addr[11:2]; pwdata = d; pstrb = s;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input bit side, input logic [11:0] addr, input logic [31:0] exp,
                    input string tag);
    @(negedge pclk);
    sel_a = !side; sel_b = side; pwrite = 1'b0; penable = 1'b0;
    paddr_w = addr[11:2]; pstrb = 4'h0;
    exp_q.push_back('{side, exp});
    tag_q.push_back(tag);
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0;
  endtask

  // Monitor: compares each completed read with the oldest expectation
  always @(negedge pclk) begin
    #1;
    if ((sel_a || sel_b) && penable && !pwrite) begin
      exp_t  e;
      string t;
      if (exp_q.size() == 0) begin
        chk("R2 unexpected read", 32'h1, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, e.side ? prdata_b : prdata_a, e.exp);
        chk("R2 ready/error", {30'b0, e.side ? pready_b : pready_a,
                                     e.side ? pslverr_b : pslverr_a}, 32'h2);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    chk("R1 vec0 one", vec0_b, 32'h1000_0000);
    chk("R1 vec1 two", vec1_a, 32'h1000_0000);
    chk("R1 no pulses", {28'b0, rel_a, rel_b} | {31'b0, swr_a | swr_b}, 32'h0);
    rd(0, 12'h100, 32'h1,          "R1 reset cause");
    rd(0, 12'h200, 32'h7F,         "R1 system sense");
    rd(0, 12'h110, 32'h1000_0000,  "R1 vector 0");
    rd(0, 12'h114, 32'h1000_0000,  "R1 vector 1");
    rd(0, 12'h000, 32'h0,          "R1 debug status");
    rd(0, 12'h10C, 32'h0,          "R1 retention");
    rd(1, 12'h1FC, 32'h3,          "R1 power control");

    // R2 byte lanes
    wr(0, 12'h10C, 32'hDEAD_BEEF, 4'hF);
    rd(0, 12'h10C, 32'hDEAD_BEEF,  "R2 full write");
    wr(0, 12'h10C, 32'h1122_3344, 4'h2);
    rd(0, 12'h10C, 32'hDEAD_33EF,  "R2 lane 1 only");
    wr(0, 12'h00C, 32'hA5A5_A5A5, 4'h9);
    rd(0, 12'h00C, 32'hA500_00A5,  "R2 lanes 0 and 3");

    // R3 set/clear aliases
    wr(0, 12'h004, 32'hF0, 4'hF);
    rd(0, 12'h000, 32'hF0,         "R3 set");
    wr(0, 12'h004, 32'h03, 4'hF);
    rd(0, 12'h000, 32'hF3,         "R3 set accumulates");
    wr(0, 12'h008, 32'h30, 4'hF);
    rd(0, 12'h000, 32'hC3,         "R3 clear");
    rd(0, 12'h004, 32'h0,          "R3 set alias reads zero");
    rd(0, 12'h008, 32'h0,          "R3 clear alias reads zero");
    wr(0, 12'h000, 32'hFFFF, 4'hF);
    rd(0, 12'h000, 32'hC3,         "R10 status write ignored");

    // R4 software reset
    wr(0, 12'h108, 32'h200, 4'hF);
    chk("R4 request high", {31'b0, swr_a}, 32'h1);
    @(negedge pclk);
    chk("R4 request one clock", {31'b0, swr_a}, 32'h0);
    wr(0, 12'h108, 32'hFFFF_FDFF, 4'hF);
    chk("R4 other bits ignored", {31'b0, swr_a}, 32'h0);
    rd(0, 12'h108, 32'h0,          "R3 reset word reads zero");

    // R5 release pulses, two-core
    wr(0, 12'h118, 32'h3, 4'hF);
    chk("R5 no pulse on set", {30'b0, rel_a}, 32'h0);
    wr(0, 12'h118, 32'h1, 4'hF);
    chk("R5 core 1 release", {30'b0, rel_a}, 32'h2);
    @(negedge pclk);
    chk("R5 release one clock", {30'b0, rel_a}, 32'h0);
    wr(0, 12'h118, 32'h0, 4'hF);
    chk("R5 core 0 release", {30'b0, rel_a}, 32'h1);
    // R5 single-core
    wr(1, 12'h120, 32'h3, 4'hF);
    wr(1, 12'h120, 32'h0, 4'hF);
    chk("R5 one-core release", {30'b0, rel_b}, 32'h1);
    wr(1, 12'h120, 32'h2, 4'hF);
    wr(1, 12'h120, 32'h0, 4'hF);
    chk("R5 absent core silent", {30'b0, rel_b}, 32'h0);

    // R6 vector lock
    wr(1, 12'h110, 32'h2000_00FE, 4'hF);
    chk("R6 trimmed vector", vec0_b, 32'h2000_0080);
    wr(1, 12'h110, 32'h3000_01FF, 4'hF);
    chk("R6 vector after lock write", vec0_b, 32'h3000_0180);
    wr(1, 12'h110, 32'h4000_0000, 4'hF);
    rd(1, 12'h110, 32'h3000_01FF,  "R6 locked word");
    chk("R6 locked vector", vec0_b, 32'h3000_0180);
    wr(0, 12'h110, 32'h0000_0001, 4'hF);
    wr(0, 12'h110, 32'h1234_5679, 4'hF);
    chk("R6 two-core full vector", vec0_a, 32'h1234_5679);

    // R7 power lock
    wr(1, 12'h1FC, 32'h2, 4'hF);
    rd(1, 12'h1FC, 32'h2,          "R7 unlocked write");
    wr(1, 12'h1FC, 32'h3, 4'hF);
    rd(1, 12'h1FC, 32'h2,          "R7 locked write dropped");

    // R8 variant maps
    wr(1, 12'h114, 32'h55, 4'hF);
    rd(1, 12'h114, 32'h0,          "R8 one-core 0x114 invalid");
    rd(1, 12'h118, 32'h0,          "R8 one-core 0x118 invalid");
    wr(1, 12'h124, 32'hA5, 4'hF);
    rd(1, 12'h124, 32'hA5,         "R8 one-core NMI at 0x124");
    rd(1, 12'h11C, 32'h0,          "R8 one-core 0x11C invalid");
    wr(0, 12'h1FC, 32'h7, 4'hF);
    rd(0, 12'h1FC, 32'h0,          "R8 two-core 0x1FC invalid");
    rd(0, 12'h204, 32'h0,          "R8 two-core 0x204 invalid");
    wr(1, 12'h204, 32'h9, 4'hF);
    rd(1, 12'h204, 32'h9,          "R8 one-core core sense");
    rd(1, 12'h20C, 32'h0,          "R8 one-core 0x20C invalid");
    wr(0, 12'h124, 32'h77, 4'hF);
    rd(0, 12'h124, 32'h77,         "R8 two-core early wake");
    rd(0, 12'h11C, 32'h0,          "R8 two-core NMI untouched");

    // R9 ID words
    rd(0, 12'hFD0, 32'h04, "R9 id 0");
    rd(0, 12'hFE0, 32'h54, "R9 id 4");
    rd(0, 12'hFE4, 32'hB8, "R9 id 5");
    rd(1, 12'hFE8, 32'h1B, "R9 id 6");
    rd(1, 12'hFF4, 32'hF0, "R9 id 9");
    rd(0, 12'hFFC, 32'hB1, "R9 id 11");
    wr(0, 12'hFE0, 32'h0, 4'hF);
    rd(0, 12'hFE0, 32'h54, "R9 id write ignored");

    // R10 unmapped
    wr(0, 12'h800, 32'hFFFF_FFFF, 4'hF);
    rd(0, 12'h800, 32'h0,  "R10 unmapped reads zero");
    rd(0, 12'h10C, 32'hDEAD_33EF, "R10 unmapped write harmless");

    repeat (2) @(negedge pclk);
    chk("R2 all reads seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule